// File: doc/BRIEF.md
# Phase Detector with Lock Detect

This block compares, for each of two synthesizer sections (index 0 = IF, index 1 = RF), a reference pulse stream with a divided-oscillator pulse stream. Both streams are already synchronous to the reference oscillator clock. For each section it drives the two switch enables of an external charge pump. When neither enable is high, the pump output is high-impedance. A polarity bit per section chooses which enable answers a leading reference. The block also counts the phase error in clock periods to qualify a per-section lock flag.

A per-section sleep input silences that section's pump and makes its lock read as locked. The shared output pin carries either the AND of both sections' lock flags, or one of the four raw input streams for monitoring.

Top module: `pfd_lock_detect`

## Requirements
- R1: When a reference rising edge comes d clock cycles before the matching feedback rising edge (1 <= d), exactly one enable is high for exactly d cycles. With polarity 1 that enable is pumpHi; with polarity 0 it is pumpLo. When the feedback edge leads, the roles swap.
- R2: Outside a lead interval and outside the pulse of R3, both enables of a section are low (high-impedance).
- R3: Rising edges on both streams in the same cycle raise both enables together for exactly one cycle, and never for two cycles in a row.
- R4: The error counter saturates at 2**CNT_W-1. A lead longer than that counts as a large error and does not wrap to a small one.
- R5: A locked section becomes unlocked once the lead reaches UNLOCK_TH (8) cycles. The drop shows in the cycle after the 8th cycle of the lead, even before the lagging edge arrives. Shorter errors keep lock.
- R6: An unlocked section becomes locked on the third consecutive comparison whose error is below LOCK_TH (16). An error of 16 or more restarts the count. An error from 8 to 15 qualifies while the section is unlocked.
- R7: While saveMode[i] is 1, section i's enables are low and its lock reads 1. The qualification count is cleared, so after release three fresh qualifying comparisons are needed.
- R8: With monSel 0, lockPin is 1 only when both sections read locked.
- R9: With monSel 1, lockPin follows a raw stream chosen by testSel (bit 0 and bit 1): 00 refIn[0], 01 refIn[1], 10 fbIn[0], 11 fbIn[1].
- R10: After reset, all enables are low and both sections are unlocked, so lockPin is 0 with monSel 0 and no section sleeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference oscillator clock |
| rstN | input | 1 | active-low reset |
| refIn | input | 2 | reference pulse streams, [0] IF, [1] RF |
| fbIn | input | 2 | divided-oscillator pulse streams |
| polarity | input | 2 | per-section pump polarity |
| saveMode | input | 2 | per-section sleep, 1 = sleeping |
| monSel | input | 1 | 1 = monitor stream on lockPin, 0 = lock |
| testSel | input | 2 | monitor stream select |
| pumpHi | output | 2 | pump source enable per section |
| pumpLo | output | 2 | pump sink enable per section |
| lockPin | output | 1 | combined lock or monitored stream |

## Verification
An edge driven at a falling clock edge is seen at the next rising edge, which is cycle k. The enables change right after k and fall right after the rising edge that sees the lagging edge. The bench samples 2 ns after every rising edge and counts enable cycles over a window that runs two cycles past the expected end. Lock flags update at the rising edge of the lagging edge, except the unlock of R5, which is due at k+8 and is checked by recording the first sample index at which lockPin is low. The monitor path is combinational, so it is checked 2 ns after each drive.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  localparam int NSEC   = 2;
  localparam int SEC_IF = 0;
  localparam int SEC_RF = 1;

  typedef enum logic [1:0] {PH_IDLE, PH_REF_LEAD, PH_FB_LEAD} phState_t;

  typedef struct packed {
    logic startCnt;  // leading edge seen: counter to 1
    logic runCnt;    // lead continues: counter steps
    logic leading;   // a lead interval is open
    logic done;      // comparison finished this cycle
    logic zeroErr;   // finished with coincident edges
    logic sleepEn;   // section asleep
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_phase_ctrl.sv
module pfd_phase_ctrl
  import pfd_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refIn,
  input  logic       fbIn,
  input  logic       polarity,
  input  logic       sleepEn,
  output pfdStrobe_t strobe,
  output logic       drvHi,
  output logic       drvLo
);
  logic refQ, fbQ, zeroPulse, zeroNext;
  logic refRise, fbRise, refSide, fbSide;
  phState_t state, nextState;

  assign refRise = refIn & ~refQ;
  assign fbRise  = fbIn & ~fbQ;

  always_comb begin
    nextState       = state;
    strobe          = '0;
    zeroNext        = 1'b0;
    case (state)
      PH_IDLE: begin
        if (refRise && fbRise) begin
          strobe.done    = 1'b1;
          strobe.zeroErr = 1'b1;
          zeroNext       = 1'b1;
        end else if (refRise) begin
          nextState       = PH_REF_LEAD;
          strobe.startCnt = 1'b1;
        end else if (fbRise) begin
          nextState       = PH_FB_LEAD;
          strobe.startCnt = 1'b1;
        end
      end
      PH_REF_LEAD: begin
        strobe.leading = 1'b1;
        if (fbRise) begin
          strobe.done = 1'b1;
          nextState   = PH_IDLE;
        end else begin
          strobe.runCnt = 1'b1;
        end
      end
      PH_FB_LEAD: begin
        strobe.leading = 1'b1;
        if (refRise) begin
          strobe.done = 1'b1;
          nextState   = PH_IDLE;
        end else begin
          strobe.runCnt = 1'b1;
        end
      end
      default: nextState = PH_IDLE;
    endcase
    if (sleepEn) begin
      nextState = PH_IDLE;
      strobe    = '0;
      zeroNext  = 1'b0;
    end
    strobe.sleepEn = sleepEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ      <= 1'b0;
      fbQ       <= 1'b0;
      state     <= PH_IDLE;
      zeroPulse <= 1'b0;
    end else begin
      refQ      <= refIn;
      fbQ       <= fbIn;
      state     <= nextState;
      zeroPulse <= zeroNext;
    end
  end

  assign refSide = (state == PH_REF_LEAD) | zeroPulse;
  assign fbSide  = (state == PH_FB_LEAD) | zeroPulse;
  assign drvHi   = ~sleepEn & (polarity ? refSide : fbSide);
  assign drvLo   = ~sleepEn & (polarity ? fbSide : refSide);
endmodule

// File: rtl/pfd_lock_track.sv
module pfd_lock_track
  import pfd_lock_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int UNLOCK_TH = 8,
  parameter int LOCK_TH   = 16,
  parameter int QUAL_N    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t strobe,
  output logic       lockOut
);
  localparam int QW = $clog2(QUAL_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] UNLOCK_V = CNT_W'(UNLOCK_TH);
  localparam logic [CNT_W-1:0] LOCK_V   = CNT_W'(LOCK_TH);
  localparam logic [QW-1:0]    QUAL_END = QW'(QUAL_N - 1);

  logic [CNT_W-1:0] errCnt, errNow;
  logic [QW-1:0]    qual;
  logic             locked;

  assign errNow = strobe.zeroErr ? '0 : errCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt <= '0;
    end else if (strobe.startCnt) begin
      errCnt <= CNT_W'(1);
    end else if (strobe.runCnt && errCnt != CNT_MAX) begin
      errCnt <= errCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b0;
      qual   <= '0;
    end else if (strobe.sleepEn) begin
      qual <= '0;
    end else if (locked && strobe.leading && errCnt >= UNLOCK_V) begin
      locked <= 1'b0;
      qual   <= '0;
    end else if (strobe.done && !locked) begin
      if (errNow < LOCK_V) begin
        if (qual == QUAL_END) begin
          locked <= 1'b1;
          qual   <= '0;
        end else begin
          qual <= qual + QW'(1);
        end
      end else begin
        qual <= '0;
      end
    end
  end

  assign lockOut = locked | strobe.sleepEn;
endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
  import pfd_lock_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int UNLOCK_TH = 8,
  parameter int LOCK_TH   = 16,
  parameter int QUAL_N    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] refIn,
  input  logic [1:0] fbIn,
  input  logic [1:0] polarity,
  input  logic [1:0] saveMode,
  input  logic       monSel,
  input  logic [1:0] testSel,
  output logic [1:0] pumpHi,
  output logic [1:0] pumpLo,
  output logic       lockPin
);
  logic [NSEC-1:0] secLock;
  logic            monStream;
  pfdStrobe_t      strobeSec [NSEC];

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    pfd_phase_ctrl u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .refIn   (refIn[g]),
      .fbIn    (fbIn[g]),
      .polarity(polarity[g]),
      .sleepEn (saveMode[g]),
      .strobe  (strobeSec[g]),
      .drvHi   (pumpHi[g]),
      .drvLo   (pumpLo[g])
    );
    pfd_lock_track #(
      .CNT_W    (CNT_W),
      .UNLOCK_TH(UNLOCK_TH),
      .LOCK_TH  (LOCK_TH),
      .QUAL_N   (QUAL_N)
    ) u_track (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobeSec[g]),
      .lockOut(secLock[g])
    );
  end

  always_comb begin
    case (testSel)
      2'b00:   monStream = refIn[SEC_IF];
      2'b01:   monStream = refIn[SEC_RF];
      2'b10:   monStream = fbIn[SEC_IF];
      default: monStream = fbIn[SEC_RF];
    endcase
  end

  assign lockPin = monSel ? monStream : (&secLock);
endmodule

// File: rtl/pfd_lock_detect_chk.sv
module pfd_lock_detect_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] refIn,
  input logic [1:0] fbIn,
  input logic [1:0] saveMode,
  input logic       monSel,
  input logic [1:0] testSel,
  input logic [1:0] pumpHi,
  input logic [1:0] pumpLo,
  input logic       lockPin,
  input logic [1:0] secLock
);
  for (genvar i = 0; i < 2; i++) begin : g_a
    a_r3_single_overlap: assert property (@(posedge clk) disable iff (!rstN)
      (pumpHi[i] && pumpLo[i]) |=> !(pumpHi[i] && pumpLo[i]));
    a_r7_quiet_pump: assert property (@(posedge clk) disable iff (!rstN)
      (saveMode[i] && $past(saveMode[i])) |-> (!pumpHi[i] && !pumpLo[i]));
    a_r7_sleep_locked: assert property (@(posedge clk) disable iff (!rstN)
      saveMode[i] |-> secLock[i]);
    a_r5_drop_in_lead: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(secLock[i]) && !$past(saveMode[i])) |-> $past(pumpHi[i] || pumpLo[i]));
  end

  a_r9_mon_ref_if: assert property (@(posedge clk) disable iff (!rstN)
    (monSel && testSel == 2'b00) |-> (lockPin == refIn[0]));
  a_r9_mon_fb_rf: assert property (@(posedge clk) disable iff (!rstN)
    (monSel && testSel == 2'b11) |-> (lockPin == fbIn[1]));
  a_r8_and_lock: assert property (@(posedge clk) disable iff (!rstN)
    (!monSel && lockPin) |-> (secLock == 2'b11));
endmodule

bind pfd_lock_detect pfd_lock_detect_chk u_chk (.*);

// File: tb/pfd_lock_detect_tb.sv
module pfd_lock_detect_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] refIn = '0, fbIn = '0, polarity = '0, saveMode = '0, testSel = '0;
  logic monSel = 1'b0;
  logic [1:0] pumpHi, pumpLo;
  logic lockPin;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pfd_lock_detect u_dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // mode 0: ref leads, 1: fb leads, 2: coincident
  task automatic runPair(input int sec, input int mode, input int d,
                         output int hiN, output int loN, output int bothN, output int dropAt);
    int last;
    hiN = 0; loN = 0; bothN = 0; dropAt = -1;
    @(negedge clk);
    if (mode == 0) refIn[sec] = 1'b1;
    else if (mode == 1) fbIn[sec] = 1'b1;
    else begin refIn[sec] = 1'b1; fbIn[sec] = 1'b1; end
    last = (mode == 2) ? 2 : d + 2;
    for (int j = 0; j <= last; j++) begin
      @(posedge clk); #2;
      if (pumpHi[sec]) hiN++;
      if (pumpLo[sec]) loN++;
      if (pumpHi[sec] && pumpLo[sec]) bothN++;
      if (!lockPin && dropAt < 0) dropAt = j;
      if (mode < 2 && j == d - 1) begin
        @(negedge clk);
        if (mode == 0) fbIn[sec] = 1'b1; else refIn[sec] = 1'b1;
      end
    end
    @(negedge clk);
    refIn[sec] = 1'b0; fbIn[sec] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cyc(input int sec, input int d);
    int h, l, b, dr;
    runPair(sec, (d == 0) ? 2 : 0, d, h, l, b, dr);
  endtask

  task automatic pinNow(input int exp, input string tag);
    @(negedge clk); #2;
    check(lockPin == exp[0], tag, lockPin, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h, l, b, dr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    // R10 reset state
    check(pumpHi == 2'b00 && pumpLo == 2'b00, "R10 pumps idle after reset", {pumpHi, pumpLo}, 0);
    check(lockPin == 1'b0, "R10 unlocked after reset", lockPin, 0);

    // R1 / R2 width and direction sweep on the IF section, RF asleep
    saveMode = 2'b10;
    for (int p = 0; p < 2; p++) begin
      polarity[0] = p[0];
      for (int m = 0; m < 2; m++) begin
        for (int d = 1; d <= 20; d++) begin
          int eh, el;
          runPair(0, m, d, h, l, b, dr);
          eh = ((p == 1) == (m == 0)) ? d : 0;
          el = d - eh;
          check(h == eh, "R1 source enable width", h, eh);
          check(l == el && b == 0, "R2 sink width and no overlap", l, el);
        end
      end
      // R3 coincident edges
      runPair(0, 2, 0, h, l, b, dr);
      check(h == 1 && l == 1 && b == 1, "R3 one-cycle balanced pulse", b, 1);
    end

    // R5 / R6 lock sweep
    polarity[0] = 1'b1;
    for (int d = 0; d <= 20; d++) begin
      cyc(0, 20);
      cyc(0, d); cyc(0, d);
      pinNow(0, "R6 not locked after two comparisons");
      cyc(0, d);
      pinNow((d < 16) ? 1 : 0, "R6 lock on third comparison");
      if (d < 16) begin
        runPair(0, (d == 0) ? 2 : 0, d, h, l, b, dr);
        check(dr == ((d >= 8) ? 8 : -1), "R5 unlock point", dr, (d >= 8) ? 8 : -1);
      end
    end

    // R4 saturation: a 70-cycle lead must not wrap to 6
    cyc(0, 20);
    cyc(0, 3); cyc(0, 3);
    cyc(0, 70);
    cyc(0, 3);
    pinNow(0, "R4 long lead resets qualification");
    cyc(0, 3); cyc(0, 3);
    pinNow(1, "R4 relock after saturation");

    // R6 on the RF section with feedback leading
    saveMode = 2'b01;
    polarity[1] = 1'b0;
    runPair(1, 1, 20, h, l, b, dr);
    for (int k = 0; k < 3; k++) runPair(1, 1, 5, h, l, b, dr);
    pinNow(1, "R6 RF section locks");
    check(h == 5 && l == 0, "R1 RF fb lead with polarity 0", h, 5);

    // R8 combined lock
    saveMode = 2'b00;
    pinNow(1, "R8 both locked");
    cyc(1, 20);
    pinNow(0, "R8 RF unlocked gives 0");
    cyc(1, 2); cyc(1, 2); cyc(1, 2);
    pinNow(1, "R8 both locked again");
    cyc(0, 20);
    pinNow(0, "R8 IF unlocked gives 0");

    // R7 sleep
    saveMode = 2'b11;
    pinNow(1, "R7 sleeping reads locked");
    runPair(0, 0, 10, h, l, b, dr);
    check(h == 0 && l == 0, "R7 pump silent asleep", h + l, 0);
    check(dr == -1, "R7 lock stays high asleep", dr, -1);
    saveMode = 2'b10;
    cyc(0, 3); cyc(0, 3);
    saveMode = 2'b11;
    repeat (3) @(negedge clk);
    saveMode = 2'b10;
    cyc(0, 3);
    pinNow(0, "R7 qualification cleared by sleep");
    cyc(0, 3); cyc(0, 3);
    pinNow(1, "R7 lock after three fresh comparisons");

    // R9 monitor multiplexer
    saveMode = 2'b11;
    monSel = 1'b1;
    for (int t = 0; t < 4; t++) begin
      testSel = t[1:0];
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        refIn = {s == 1, s == 0};
        fbIn  = {s == 3, s == 2};
        #2;
        check(lockPin == (s == t), "R9 monitor select", lockPin, (s == t) ? 1 : 0);
      end
    end
    @(negedge clk);
    refIn = '0; fbIn = '0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule